// File: doc/BRIEF.md
# Key-Protected Windowed Watchdog Timer

This block is a watchdog built around a 12-bit down-counter. A power-of-two prescaler drives the counter. Software controls the block through a small register bus. Every command goes through one key register, and only specific 16-bit patterns written there have any effect. One pattern starts the counter and one reloads it. Two more open and close write access to the three configuration registers: divider code, reload value and window value. All other patterns do nothing.

Once the counter is started, nothing can stop it except a block reset. If the counter runs down past zero, the block raises a one-cycle reset request. It raises the same request if software refreshes too early, while the counter is still above an enabled window value. After a reset request the block goes inert until it is reset.

A write accepted into a configuration register passes through a busy phase. The busy phase models the hand-off into the counting logic. During that phase the matching status bit reads 1, further writes to that register are dropped, and the counter keeps using the previous value. The bus is a plain single-cycle register interface with no back-pressure. A write takes effect on the clock edge where `bus_wr` is high. Read data is combinational from `bus_addr`.

Top module: `wdg_keyed_top`

## Requirements
- R1: After reset, `rst_req` is 0 and the registers read back as follows: divider code (address 1) reads 0, reload (address 2) reads 0xFFF, window (address 3) reads 0xFFF, status (address 4) reads 0. The key register is at address 0.
- R2: Writing 0xCCCC to the key register while idle loads the counter from the reload value and starts it. `rst_req` is then high for exactly one cycle, sampled after clock edge E+D·(reload+1), where E is the key write edge and D is the division ratio.
- R3: Divider codes 0 to 6 give D = 4, 8, 16, 32, 64, 128 and 256. Code 7 behaves like code 6.
- R4: Writing 0xAAAA while running, and not too early, reloads the counter and restarts the prescaler phase. The next expiry then follows the R2 timing, measured from the refresh edge.
- R5: A refresh while the counter is strictly above the window value makes `rst_req` high in the cycle right after the refresh edge. A counter equal to the window value is accepted. A window of 0xFFF never causes a fault.
- R6: 0x5555 opens write access to the configuration registers and 0x0000 closes it. Configuration writes while access is closed leave the register unchanged and set no busy flag.
- R7: An accepted configuration write sets its status bit (bit 0 divider, bit 1 reload, bit 2 window). The bit clears after 2 prescaler ticks. A write to that register while its bit is set is ignored.
- R8: Once started, no key value stops the counter. After a reset request the block ignores all keys and never raises `rst_req` again until block reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address (0 key, 1 divider, 2 reload, 3 window, 4 status) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` |
| rst_req | output | 1 | One-cycle reset request |

## Verification
The bench measures the expiry delay to the exact cycle across divider codes, including a reload of zero. An off-by-one in the divider or the terminal count would move the pulse one tick early or late. It probes the window edge with a refresh at counter = window+1 and another at counter = window. A design that compares the wrong way would fault on the legal refresh or accept the early one. It also checks locked writes, writes during busy, stop attempts with non-start keys, and keys written after expiry. A design that is lax there would change the read-back values, stop counting, or pulse `rst_req` a second time.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  localparam int KEY_W  = 16;
  localparam int ADDR_W = 3;

  localparam logic [KEY_W-1:0] KEY_START = 16'hCCCC;
  localparam logic [KEY_W-1:0] KEY_FEED  = 16'hAAAA;
  localparam logic [KEY_W-1:0] KEY_OPEN  = 16'h5555;
  localparam logic [KEY_W-1:0] KEY_SHUT  = 16'h0000;

  localparam logic [ADDR_W-1:0] ADR_KEY  = 3'd0;
  localparam logic [ADDR_W-1:0] ADR_PSC  = 3'd1;
  localparam logic [ADDR_W-1:0] ADR_RLD  = 3'd2;
  localparam logic [ADDR_W-1:0] ADR_WIN  = 3'd3;
  localparam logic [ADDR_W-1:0] ADR_STAT = 3'd4;

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_DONE} wstate_e;
endpackage

// File: rtl/wdg_prescale.sv
module wdg_prescale #(
  parameter int PSC_W     = 3,
  parameter int BASE_LOG2 = 2,
  parameter int MAX_CODE  = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [PSC_W-1:0] code,
  output logic             tick
);
  localparam int DIV_W = BASE_LOG2 + MAX_CODE;

  logic [DIV_W-1:0] pcnt_q;
  logic [DIV_W-1:0] mask;
  logic [PSC_W-1:0] sel;
  int               shamt;

  // codes above the last legal one saturate to the slowest rate
  always_comb begin
    sel   = (int'(code) > MAX_CODE) ? PSC_W'(MAX_CODE) : code;
    shamt = BASE_LOG2 + int'(sel);
    mask  = DIV_W'((64'd1 << shamt) - 64'd1);
    tick  = ((pcnt_q & mask) == mask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pcnt_q <= '0;
    else if (restart) pcnt_q <= '0;
    else              pcnt_q <= pcnt_q + 1'b1;
  end

  // R4: a restarted phase never ticks on the following cycle
  p_restart_phase_r4: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !tick);
endmodule

// File: rtl/wdg_sync_slot.sv
module wdg_sync_slot #(
  parameter int             DW      = 12,
  parameter int             TICKS   = 2,
  parameter logic [DW-1:0]  RST_VAL = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [DW-1:0] din,
  input  logic          tick,
  output logic          busy_q,
  output logic [DW-1:0] shadow_q,
  output logic [DW-1:0] active_q
);
  localparam int TW = (TICKS < 2) ? 1 : $clog2(TICKS);

  logic [TW-1:0] tcnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      tcnt_q   <= '0;
      shadow_q <= RST_VAL;
      active_q <= RST_VAL;
    end else if (wr && !busy_q) begin
      busy_q   <= 1'b1;
      tcnt_q   <= '0;
      shadow_q <= din;
    end else if (busy_q && tick) begin
      if (int'(tcnt_q) == TICKS - 1) begin
        busy_q   <= 1'b0;
        active_q <= shadow_q;
      end else begin
        tcnt_q <= tcnt_q + 1'b1;
      end
    end
  end

  // R7: a pending update cannot be overwritten
  p_hold_while_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |=> $stable(shadow_q));
  // R7: the counting side only changes value at a tick that ends the busy phase
  p_active_waits_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy_q && tick) |=> $stable(active_q));
endmodule

// File: rtl/wdg_regs.sv
module wdg_regs
  import wdg_pkg::*;
#(
  parameter int CNT_W = 12,
  parameter int PSC_W = 3,
  parameter int TICKS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [KEY_W-1:0]  bus_wdata,
  output logic [KEY_W-1:0]  bus_rdata,
  input  logic              tick,
  output logic              key_start,
  output logic              key_feed,
  output logic [PSC_W-1:0]  act_psc,
  output logic [CNT_W-1:0]  act_rld,
  output logic [CNT_W-1:0]  act_win
);
  localparam int N_WIDE = 2;

  logic             open_q;
  logic             key_wr;
  logic             psc_wr, psc_busy;
  logic [PSC_W-1:0] psc_shadow;
  logic [N_WIDE-1:0] wide_wr, wide_busy;
  logic [CNT_W-1:0] wide_shadow [N_WIDE];
  logic [CNT_W-1:0] wide_active [N_WIDE];

  assign key_wr    = bus_wr && (bus_addr == ADR_KEY);
  assign key_start = key_wr && (bus_wdata == KEY_START);
  assign key_feed  = key_wr && (bus_wdata == KEY_FEED);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                open_q <= 1'b0;
    else if (key_wr && bus_wdata == KEY_OPEN)  open_q <= 1'b1;
    else if (key_wr && bus_wdata == KEY_SHUT)  open_q <= 1'b0;
  end

  assign psc_wr = bus_wr && open_q && (bus_addr == ADR_PSC);

  wdg_sync_slot #(.DW(PSC_W), .TICKS(TICKS), .RST_VAL('0)) u_psc_slot (
    .clk(clk), .rst_n(rst_n), .wr(psc_wr), .din(bus_wdata[PSC_W-1:0]),
    .tick(tick), .busy_q(psc_busy), .shadow_q(psc_shadow), .active_q(act_psc)
  );

  // slot 0 holds the reload value, slot 1 the window value
  for (genvar i = 0; i < N_WIDE; i++) begin : g_wide
    assign wide_wr[i] = bus_wr && open_q && (bus_addr == ADR_RLD + ADDR_W'(i));
    wdg_sync_slot #(.DW(CNT_W), .TICKS(TICKS), .RST_VAL('1)) u_slot (
      .clk(clk), .rst_n(rst_n), .wr(wide_wr[i]), .din(bus_wdata[CNT_W-1:0]),
      .tick(tick), .busy_q(wide_busy[i]), .shadow_q(wide_shadow[i]),
      .active_q(wide_active[i])
    );
  end

  assign act_rld = wide_active[0];
  assign act_win = wide_active[1];

  always_comb begin
    unique case (bus_addr)
      ADR_PSC:  bus_rdata = KEY_W'(psc_shadow);
      ADR_RLD:  bus_rdata = KEY_W'(wide_shadow[0]);
      ADR_WIN:  bus_rdata = KEY_W'(wide_shadow[1]);
      ADR_STAT: bus_rdata = KEY_W'({wide_busy, psc_busy});
      default:  bus_rdata = '0;
    endcase
  end

  // R6: with access closed a reload write leaves the stored value alone
  p_locked_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !open_q && bus_addr == ADR_RLD) |=> $stable(wide_shadow[0]));
  // R6: with access closed no busy phase starts on the window register
  p_locked_no_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !open_q && bus_addr == ADR_WIN && !wide_busy[1]) |=> !wide_busy[1]);
endmodule

// File: rtl/wdg_core.sv
module wdg_core
  import wdg_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             key_start,
  input  logic             key_feed,
  input  logic [CNT_W-1:0] act_rld,
  input  logic [CNT_W-1:0] act_win,
  output logic             restart,
  output logic             rst_req
);
  wstate_e          state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             window_on, too_early;

  assign window_on = (act_win != '1);
  assign too_early = window_on && (cnt_q > act_win);
  assign restart   = ((state_q == S_IDLE) && key_start) ||
                     ((state_q == S_RUN) && key_feed && !too_early);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      cnt_q   <= '1;
      rst_req <= 1'b0;
    end else begin
      rst_req <= 1'b0;
      unique case (state_q)
        S_IDLE: if (key_start) begin
          state_q <= S_RUN;
          cnt_q   <= act_rld;
        end
        S_RUN: begin
          if (key_feed) begin
            if (too_early) begin
              rst_req <= 1'b1;
              state_q <= S_DONE;
            end else begin
              cnt_q <= act_rld;
            end
          end else if (tick) begin
            if (cnt_q == '0) begin
              rst_req <= 1'b1;
              state_q <= S_DONE;
            end else begin
              cnt_q <= cnt_q - 1'b1;
            end
          end
        end
        default: ;
      endcase
    end
  end

  // R2: the request is a single-cycle pulse
  p_one_cycle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);
  // R8: once started the block never returns to idle
  p_never_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != S_IDLE) |=> (state_q != S_IDLE));
  // R8: after expiry the block stays inert
  p_done_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_DONE) |=> (state_q == S_DONE && !rst_req));
  // R5: an early refresh faults on the next cycle
  p_early_fault_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_RUN && key_feed && act_win != '1 && cnt_q > act_win) |=> rst_req);
endmodule

// File: rtl/wdg_keyed_top.sv
module wdg_keyed_top
  import wdg_pkg::*;
#(
  parameter int CNT_W     = 12,
  parameter int PSC_W     = 3,
  parameter int BASE_LOG2 = 2,
  parameter int MAX_CODE  = 6,
  parameter int BUSY_TICKS = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic [2:0]  bus_addr,
  input  logic [15:0] bus_wdata,
  output logic [15:0] bus_rdata,
  output logic        rst_req
);
  logic             tick, restart, key_start, key_feed;
  logic [PSC_W-1:0] act_psc;
  logic [CNT_W-1:0] act_rld, act_win;

  wdg_regs #(.CNT_W(CNT_W), .PSC_W(PSC_W), .TICKS(BUSY_TICKS)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick(tick),
    .key_start(key_start), .key_feed(key_feed),
    .act_psc(act_psc), .act_rld(act_rld), .act_win(act_win)
  );

  wdg_prescale #(.PSC_W(PSC_W), .BASE_LOG2(BASE_LOG2), .MAX_CODE(MAX_CODE)) u_psc (
    .clk(clk), .rst_n(rst_n), .restart(restart), .code(act_psc), .tick(tick)
  );

  wdg_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_n), .tick(tick), .key_start(key_start),
    .key_feed(key_feed), .act_rld(act_rld), .act_win(act_win),
    .restart(restart), .rst_req(rst_req)
  );
endmodule

// File: tb/wdg_keyed_top_tb_top.sv
module wdg_keyed_top_tb_top;
  timeunit 1ns;
  timeprecision 100ps;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [2:0]  bus_addr = 3'd0;
  logic [15:0] bus_wdata = 16'd0;
  logic [15:0] bus_rdata;
  logic        rst_req;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  wdg_keyed_top dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rst_req(rst_req)
  );

  // divider code, reload value, expected cycles from start edge to pulse
  localparam logic [31:0] VEC [5] = '{
    {4'd0, 12'd5, 16'd24},
    {4'd1, 12'd3, 16'd32},
    {4'd2, 12'd0, 16'd16},
    {4'd3, 12'd2, 16'd96},
    {4'd6, 12'd1, 16'd512}
  };

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [2:0] a, output int v);
    @(negedge clk);
    bus_addr = a;
    #1;
    v = int'(bus_rdata);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wait_idle(input string tag);
    int v = 1;
    int n = 0;
    while (v != 0 && n < 3000) begin
      bus_read(3'd4, v);
      n++;
    end
    chk(tag, v, 0);
  endtask

  task automatic configure(input int code, input int rld, input int win);
    bus_write(3'd0, 16'h5555);
    bus_write(3'd1, 16'(code));
    bus_write(3'd2, 16'(rld));
    bus_write(3'd3, 16'(win));
    wait_idle("R7 busy clears after config");
    bus_write(3'd0, 16'h0000);
  endtask

  // called right after a key write returns; n counts edges from that write
  task automatic expect_fire(input int n, input string tag);
    int early = 0;
    repeat (n - 1) begin
      @(negedge clk);
      if (rst_req) early++;
    end
    chk({tag, " no early pulse"}, early, 0);
    @(negedge clk);
    chk({tag, " pulse"}, int'(rst_req), 1);
    @(negedge clk);
    chk({tag, " single cycle"}, int'(rst_req), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=hang expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int v;
    do_reset();

    // R1: reset state
    chk("R1 rst_req", int'(rst_req), 0);
    bus_read(3'd1, v); chk("R1 divider", v, 0);
    bus_read(3'd2, v); chk("R1 reload", v, 16'hFFF);
    bus_read(3'd3, v); chk("R1 window", v, 16'hFFF);
    bus_read(3'd4, v); chk("R1 status", v, 0);

    // R6: locked write ignored
    bus_write(3'd2, 16'h0003);
    bus_read(3'd2, v); chk("R6 locked reload", v, 16'hFFF);
    bus_read(3'd4, v); chk("R6 locked no busy", v, 0);

    // R7: busy flag and write-while-busy ignored
    bus_write(3'd0, 16'h5555);
    bus_write(3'd2, 16'h000A);
    bus_read(3'd4, v); chk("R7 reload busy bit", v, 2);
    bus_write(3'd2, 16'h0014);
    wait_idle("R7 busy clears");
    bus_read(3'd2, v); chk("R7 write during busy ignored", v, 16'h00A);
    bus_write(3'd0, 16'h0000);
    bus_write(3'd3, 16'h0005);
    bus_read(3'd3, v); chk("R6 relocked window", v, 16'hFFF);

    // R2/R3: expiry timing table
    foreach (VEC[i]) begin
      do_reset();
      configure(int'(VEC[i][31:28]), int'(VEC[i][27:16]), 12'hFFF);
      bus_write(3'd0, 16'hCCCC);
      expect_fire(int'(VEC[i][15:0]), $sformatf("R2 R3 vec%0d", i));
    end

    // R8: keys cannot stop it; inert after expiry
    do_reset();
    configure(0, 20, 12'hFFF);
    bus_write(3'd0, 16'hCCCC);
    bus_write(3'd0, 16'h0000);
    bus_write(3'd0, 16'h1234);
    bus_write(3'd0, 16'h5555);
    expect_fire(84 - 6, "R8 no stop");
    bus_write(3'd0, 16'hCCCC);
    bus_write(3'd0, 16'hAAAA);
    begin
      int seen = 0;
      repeat (300) begin
        @(negedge clk);
        if (rst_req) seen++;
      end
      chk("R8 inert after expiry", seen, 0);
    end

    // R4: refresh reloads and restarts the phase
    do_reset();
    configure(0, 30, 12'hFFF);
    bus_write(3'd0, 16'hCCCC);
    repeat (60) @(negedge clk);
    bus_write(3'd0, 16'hAAAA);
    chk("R4 refresh no fault", int'(rst_req), 0);
    expect_fire(4 * 31, "R4 refresh");

    // R5: immediate refresh above window faults
    do_reset();
    configure(0, 100, 50);
    bus_write(3'd0, 16'hCCCC);
    bus_write(3'd0, 16'hAAAA);
    chk("R5 early refresh fault", int'(rst_req), 1);
    @(negedge clk);
    chk("R5 fault single cycle", int'(rst_req), 0);

    // R5: counter = window + 1 faults
    do_reset();
    configure(0, 100, 50);
    bus_write(3'd0, 16'hCCCC);
    repeat (196) @(negedge clk);
    bus_write(3'd0, 16'hAAAA);
    chk("R5 count 51 faults", int'(rst_req), 1);

    // R5: counter = window accepted
    do_reset();
    configure(0, 100, 50);
    bus_write(3'd0, 16'hCCCC);
    repeat (200) @(negedge clk);
    bus_write(3'd0, 16'hAAAA);
    chk("R5 count 50 accepted", int'(rst_req), 0);
    expect_fire(4 * 101, "R5 after legal refresh");

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule